// File: doc/BRIEF.md
# Two-Way Set-Associative Byte Cache

This block sits between a processor and main memory and serves byte reads and byte writes on a 24-bit byte address. Memory is handled in 4-byte blocks. The address picks one set, and both lines of that set are compared against the address tag at the same time. A hit is answered in the same cycle, with no memory traffic. Writes stay in the cache (write-back) and mark the line dirty.

On a miss the block picks a victim line. An empty line is taken first. When both lines are full, the line that was used less recently is taken, as shown by a one-bit recency flag kept per line. If the victim is dirty, it is written back to memory. The missing block is then fetched into that line.

The processor side uses a blocking request: the processor holds `req_i`, `we_i`, `addr_i` and `wdata_i` steady until `ready_o` is high. The memory side is one block per transfer. The request, write flag, address and data stay steady until `mem_ack_i` is high for one cycle.

Top module: `c2w_cache`

## Requirements
- R1: The byte address is split as follows. The set index is `addr_i[SET_W+1:2]`, the tag is `addr_i[23:SET_W+2]` and the byte select is `addr_i[1:0]`. The byte select chooses bits `[8*sel+7:8*sel]` of the 32-bit block. Every memory transfer carries the block address `{tag, set}`, which equals `addr[23:2]`. With a 13-bit set index the tag is 9 bits wide. Address 0x16339C then gives tag 0x02C, set 0x0CE7 and byte 0, and address 0x008004 gives tag 0x001, set 0x0001 and byte 0.
- R2: Reset clears every valid bit, dirty bit and recency bit. The first access to any block after reset therefore misses and fetches from memory.
- R3: On a read hit, `ready_o` is high in the same cycle as the request and `rdata_o` carries the selected byte. No memory request is made.
- R4: On a write hit, `ready_o` is high in the same cycle. The selected byte is replaced, and the line becomes dirty. No memory write takes place at that time.
- R5: On a miss, the lowest-numbered invalid line of the set is filled before any valid line is evicted. Two blocks with the same set index can be held at the same time. After the fill acknowledge, the held request hits in the next cycle.
- R6: Every hit or refill sets the recency bit of the line it touches and clears that bit on the other line of the set. When both lines are valid, the line whose recency bit is clear is the victim.
- R7: A dirty victim is written to memory before the refill. The write carries the victim's own block address and its full current data, and the refill then reads the missing block.
- R8: A clean victim is replaced without any memory write.
- R9: The two lines of a set never both match the address tag at the same time.
- R10: A memory request holds its address and its write flag steady until acknowledged. `mem_we_o` is high only for write-backs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Processor access request, held until ready |
| we_i | input | 1 | 1 = byte write, 0 = byte read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write byte |
| ready_o | output | 1 | Access completes in this cycle |
| rdata_o | output | 8 | Read byte, valid with ready_o |
| mem_req_o | output | 1 | Block transfer request |
| mem_we_o | output | 1 | 1 = write-back, 0 = refill |
| mem_addr_o | output | ADDR_W-2 | Block address |
| mem_wdata_o | output | 32 | Write-back block |
| mem_rdata_i | input | 32 | Refill block, valid with mem_ack_i |
| mem_ack_i | input | 1 | Transfer done, one cycle |

## Verification
A hit answers combinationally in the cycle of the request, so the bench expects zero wait cycles. The bench memory acknowledges on the fourth edge after a request appears. A clean miss therefore completes five edges after the request, and a miss with a dirty victim completes after nine. The bench counts the negative edges until `ready_o` rises, sampling 1 ns after each negative edge, and compares that count with the expected 0, 5 or 9. It also compares the data and the memory write counts and addresses seen at that point.

// File: rtl/c2w_pkg.sv
package c2w_pkg;
  localparam int unsigned NUM_WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } c2w_state_e;
endpackage

// File: rtl/c2w_way_match.sv
module c2w_way_match #(
  parameter int unsigned TAG_W = 16,
  parameter int unsigned WAYS  = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [TAG_W-1:0]           tag_i,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag_i,
  input  logic [WAYS-1:0]            way_valid_i,
  output logic [WAYS-1:0]            hit_o
);
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_o[g] = way_valid_i[g] && (way_tag_i[g] == tag_i);
  end

  assert_single_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hit_o) <= 1);
endmodule

// File: rtl/c2w_victim_pick.sv
module c2w_victim_pick (
  input  logic [1:0] valid_i,
  input  logic [1:0] use_i,
  output logic       way_o
);
  // empty line first, then the line whose recency bit is clear
  always_comb begin
    if (!valid_i[0])      way_o = 1'b0;
    else if (!valid_i[1]) way_o = 1'b1;
    else                  way_o = use_i[0];
  end
endmodule

// File: rtl/c2w_cache.sv
module c2w_cache #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned SET_W  = 6,
  parameter int unsigned OFS_W  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [7:0]              wdata_i,
  output logic                    ready_o,
  output logic [7:0]              rdata_o,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [ADDR_W-OFS_W-1:0] mem_addr_o,
  output logic [(8<<OFS_W)-1:0]   mem_wdata_o,
  input  logic [(8<<OFS_W)-1:0]   mem_rdata_i,
  input  logic                    mem_ack_i
);
  import c2w_pkg::*;

  localparam int unsigned WAYS     = NUM_WAYS;
  localparam int unsigned TAG_W    = ADDR_W - SET_W - OFS_W;
  localparam int unsigned NUM_SETS = 1 << SET_W;
  localparam int unsigned BLK_W    = 8 << OFS_W;

  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  tag;
  logic [OFS_W-1:0]  sel;

  logic [WAYS-1:0][TAG_W-1:0] way_tag;
  logic [WAYS-1:0][BLK_W-1:0] way_data;
  logic [WAYS-1:0]            way_valid, way_dirty, way_use, hit;

  c2w_state_e state_q;
  logic       victim_q, vict_way, hit_any, hit_way, acc_way;
  logic       fill_done, cpu_wr_hit, touch;

  assign set_idx = addr_i[SET_W+OFS_W-1:OFS_W];
  assign tag     = addr_i[ADDR_W-1:SET_W+OFS_W];
  assign sel     = addr_i[OFS_W-1:0];

  c2w_way_match #(.TAG_W(TAG_W), .WAYS(WAYS)) i_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tag_i      (tag),
    .way_tag_i  (way_tag),
    .way_valid_i(way_valid),
    .hit_o      (hit)
  );

  c2w_victim_pick i_victim (
    .valid_i(way_valid),
    .use_i  (way_use),
    .way_o  (vict_way)
  );

  assign hit_any    = |hit;
  assign hit_way    = hit[1];
  assign ready_o    = (state_q == ST_IDLE) && req_i && hit_any;
  assign rdata_o    = way_data[hit_way][{sel, 3'b000} +: 8];
  assign fill_done  = (state_q == ST_FILL) && mem_ack_i;
  assign cpu_wr_hit = ready_o && we_i;
  assign touch      = ready_o || fill_done;
  assign acc_way    = (state_q == ST_FILL) ? victim_q : hit_way;

  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_we_o    = (state_q == ST_WBACK);
  assign mem_addr_o  = mem_we_o ? {way_tag[victim_q], set_idx} : {tag, set_idx};
  assign mem_wdata_o = way_data[victim_q];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]    tag_q  [NUM_SETS];
    logic [BLK_W-1:0]    data_q [NUM_SETS];
    logic [NUM_SETS-1:0] valid_q, dirty_q, use_q;
    logic                fill_me, write_me;

    assign fill_me      = fill_done && (victim_q == 1'(w));
    assign write_me     = cpu_wr_hit && hit[w];
    assign way_tag[w]   = tag_q[set_idx];
    assign way_data[w]  = data_q[set_idx];
    assign way_valid[w] = valid_q[set_idx];
    assign way_dirty[w] = dirty_q[set_idx];
    assign way_use[w]   = use_q[set_idx];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= '0;
        dirty_q <= '0;
        use_q   <= '0;
      end else begin
        if (fill_me) begin
          valid_q[set_idx] <= 1'b1;
          dirty_q[set_idx] <= 1'b0;
        end
        if (write_me) dirty_q[set_idx] <= 1'b1;
        if (touch)    use_q[set_idx]   <= (acc_way == 1'(w));
      end
    end

    always_ff @(posedge clk_i) begin
      if (fill_me) begin
        tag_q[set_idx]  <= tag;
        data_q[set_idx] <= mem_rdata_i;
      end else if (write_me) begin
        data_q[set_idx][{sel, 3'b000} +: 8] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      victim_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i && !hit_any) begin
          victim_q <= vict_way;
          state_q  <= (way_valid[vict_way] && way_dirty[vict_way]) ? ST_WBACK : ST_FILL;
        end
        ST_WBACK: if (mem_ack_i) state_q <= ST_FILL;
        ST_FILL:  if (mem_ack_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assert_first_invalid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_i && !hit_any && !way_valid[0]) |=> (victim_q == 1'b0));

  assert_fill_then_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_done && req_i) |=> (hit_any && ready_o));

  assert_use_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&way_use));

  assert_wb_dirty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WBACK) |-> (way_valid[victim_q] && way_dirty[victim_q]));

  assert_mem_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

// File: tb/test_c2w_cache.sv
`timescale 1ns/1ps
module test_c2w_cache;
  localparam int ADDR_W = 24;
  localparam int SET_W  = 2;
  localparam int MA_W   = ADDR_W - 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic              req_i = 1'b0, we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0]        wdata_i = '0;
  logic              ready_o, mem_req_o, mem_we_o, mem_ack_i;
  logic [7:0]        rdata_o;
  logic [MA_W-1:0]   mem_addr_o;
  logic [31:0]       mem_wdata_o, mem_rdata_i;

  c2w_cache #(.ADDR_W(ADDR_W), .SET_W(SET_W)) i_c2w_cache (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ready_o(ready_o), .rdata_o(rdata_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i)
  );

  function automatic logic [7:0] init_byte(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  // memory model: acknowledges on the fourth edge of a request
  logic [31:0]     mem [64];
  logic [MA_W-1:0] last_wr_addr, last_rd_addr, hold_addr;
  logic [31:0]     last_wr_data;
  int              wr_cnt, rd_cnt, hold_bad, cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 64; b++)
        mem[b] <= {init_byte(4*b+3), init_byte(4*b+2), init_byte(4*b+1), init_byte(4*b)};
      mem_ack_i <= 1'b0; mem_rdata_i <= '0; cnt <= 0; wr_cnt <= 0; rd_cnt <= 0;
      hold_bad <= 0; hold_addr <= '0; last_wr_addr <= '0; last_rd_addr <= '0; last_wr_data <= '0;
    end else if (mem_req_o && !mem_ack_i) begin
      if (cnt == 0) hold_addr <= mem_addr_o;
      else if (mem_addr_o != hold_addr) hold_bad <= hold_bad + 1;
      if (cnt == 2) begin
        mem_ack_i <= 1'b1;
        cnt <= 0;
        if (mem_we_o) begin
          mem[mem_addr_o[5:0]] <= mem_wdata_o;
          wr_cnt <= wr_cnt + 1; last_wr_addr <= mem_addr_o; last_wr_data <= mem_wdata_o;
        end else begin
          mem_rdata_i <= mem[mem_addr_o[5:0]];
          rd_cnt <= rd_cnt + 1; last_rd_addr <= mem_addr_o;
        end
      end else cnt <= cnt + 1;
    end else mem_ack_i <= 1'b0;
  end

  int n_chk = 0, n_bad = 0;
  logic [7:0] gold [256];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int waits);
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    #1;
    waits = 0;
    while (!ready_o && waits < 100) begin
      @(negedge clk_i); #1; waits++;
    end
    rd = rdata_o;
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [ADDR_W-1:0] a, input int exp_w, input string tag);
    logic [7:0] r; int wt;
    access(1'b0, a, 8'h00, r, wt);
    chk({tag, " data"}, 32'(r), 32'(gold[a[7:0]]));
    if (exp_w >= 0) chk({tag, " waits"}, 32'(wt), 32'(exp_w));
    else chk({tag, " R10 legal waits"}, 32'(wt == 0 || wt == 5 || wt == 9), 32'd1);
  endtask

  task automatic wr_do(input logic [ADDR_W-1:0] a, input logic [7:0] d, input int exp_w,
                       input string tag);
    logic [7:0] r; int wt;
    access(1'b1, a, d, r, wt);
    gold[a[7:0]] = d;
    if (exp_w >= 0) chk({tag, " waits"}, 32'(wt), 32'(exp_w));
    else chk({tag, " R10 legal waits"}, 32'(wt == 0 || wt == 5 || wt == 9), 32'd1);
  endtask

  localparam logic [ADDR_W-1:0] A = 24'h10, B = 24'h20, C = 24'h30;

  initial begin
    for (int i = 0; i < 256; i++) gold[i] = init_byte(i);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    #1;
    chk("R2 ready after reset", 32'(ready_o), 32'd0);
    chk("R2 no mem request after reset", 32'(mem_req_o), 32'd0);

    rd_chk(A + 1, 5, "R2 first access misses");
    chk("R1 fill block address", 32'(last_rd_addr), 32'(A >> 2));
    rd_chk(A + 2, 0, "R3 read hit");
    chk("R3 no refill on hit", 32'(rd_cnt), 32'd1);

    rd_chk(B, 5, "R5 second line filled");
    rd_chk(A, 0, "R5 first block kept");
    rd_chk(B + 3, 0, "R5 second block kept");

    rd_chk(A, 0, "R6 touch A");
    rd_chk(C, 5, "R6 C evicts B");
    chk("R8 clean victim no write", 32'(wr_cnt), 32'd0);
    rd_chk(A + 1, 0, "R6 A survived");
    rd_chk(B, 5, "R6 B was evicted");

    wr_do(A + 3, 8'h5A, 0, "R4 write hit");
    chk("R4 no memory write", 32'(wr_cnt), 32'd0);
    rd_chk(A + 3, 0, "R4 written byte");
    rd_chk(B, 0, "R6 touch B");
    rd_chk(C, 9, "R7 dirty A written back");
    chk("R7 write count", 32'(wr_cnt), 32'd1);
    chk("R7 write address", 32'(last_wr_addr), 32'(A >> 2));
    chk("R7 write data", last_wr_data, {8'h5A, gold[8'h12], gold[8'h11], gold[8'h10]});
    chk("R1 refill after write-back", 32'(last_rd_addr), 32'(C >> 2));
    rd_chk(A + 3, 5, "R7 data back from memory");
    chk("R8 clean B dropped", 32'(wr_cnt), 32'd1);
    rd_chk(24'h14, 5, "R1 other set index");
    rd_chk(A, 0, "R1 set 0 untouched");

    for (int a = 0; a < 256; a++) wr_do(24'(a), 8'(a) ^ 8'hC3, -1, "R4 sweep write");
    for (int a = 255; a >= 0; a--) rd_chk(24'(a), -1, "R9 sweep read down");
    for (int k = 0; k < 256; k++) rd_chk(24'((k * 5) & 255), -1, "R6 strided read");
    chk("R10 address held until ack", 32'(hold_bad), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule